// File: doc/BRIEF.md
# Select-Decoded Clock Post-Divider

This block divides a fast oscillator clock by one of eight ratios that a 3-bit select code picks. The code is decoded through one of two fixed ratio tables. The table is chosen by a parameter at elaboration time. The ratio set mixes even ratios, odd ratios and a divide-by-1 bypass.

Even ratios come from a rising-edge counter. Odd ratios also use a falling-edge register, which trims half an input period from the high phase. In both cases the output is high for exactly half of its period, counted in half-periods of the input. In bypass the input clock is gated straight through.

A new select value is taken only at the end of the current output period, while the output is low, so a ratio change never produces a runt pulse. An active-low power-down input stops the output in the low state. On release, counting restarts at the beginning of a high phase. A reference output is the input clock passed through unchanged. All pins are plain control or clock signals; the block has no data stream and so no valid/ready handshake.

Top module: `postdiv_top`

## Requirements
- R1: With `TABLE=0`, select codes 0,1,2,3,4,5,6,7 give divide ratios 10,2,8,4,5,7,9,6. Code 7 (`sel`=3'b111) is the all-ones code that a select left pulled up presents. A ratio N gives an output period of N input periods.
- R2: With `TABLE=1`, select codes 0,1,2,3,4,5,6,7 give divide ratios 6,2,8,4,5,7,1,3.
- R3: For every ratio N>1, even or odd, the output is high for exactly N input half-periods and low for exactly N input half-periods.
- R4: At ratio 1 the output toggles with the input clock: high for one input half-period, then low for one.
- R5: From the second rising input edge at which `pwr_n` is sampled low, `clk_out` stays low for as long as `pwr_n` stays low.
- R6: When `pwr_n` is first sampled high at a rising edge, a new period starts with its high phase. For an even ratio `clk_out` is high from that edge; for an odd ratio it is high from the following falling edge. That high phase has full length.
- R7: A change of `sel` in mid-period does not alter the period in progress. The new ratio applies from the next period boundary, and no high or low phase is shortened.
- R8: `ref_out` equals the input clock at all times.
- R9: While `rst_n` is low, `clk_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Fast oscillator clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_n | input | 1 | Active-low power-down; low stops the output low |
| sel | input | SW (3) | Ratio select code, decoded through the chosen table |
| clk_out | output | 1 | Divided output clock |
| ref_out | output | 1 | Input clock passed through |

## Verification
An even ratio's output edges are registered at a rising input edge. An odd ratio's falling-edge register moves its rising output edge half an input period later. A power-down is fully effective after the second rising edge. A select change shows only after the old period has run out.

The bench samples both outputs 1.25 ns after every input edge, so each sample is one input half-period. All checks are stated as run lengths or positions counted in these half-period samples. Inputs change right after a sample, away from any edge. This way every expected value is fixed to a known half-period slot, counted from the edge at which the stimulus is first seen.

// File: rtl/postdiv_pkg.sv
`timescale 1ns/1ps
package postdiv_pkg;
  // width of the divide-ratio field (largest ratio is 10)
  localparam int RATIO_W = 4;
  // width of the select code
  localparam int SEL_W   = 3;
endpackage

// File: rtl/postdiv_selmap.sv
`timescale 1ns/1ps
// Decodes the select code into a divide ratio through one of two tables.
module postdiv_selmap #(
  parameter int TABLE = 0,
  parameter int SW    = postdiv_pkg::SEL_W,
  parameter int RW    = postdiv_pkg::RATIO_W
) (
  input  logic [SW-1:0] sel,
  output logic [RW-1:0] ratio
);
  generate
    if (TABLE == 0) begin : g_tab_a
      // R1 mapping
      always_comb begin
        case (sel)
          3'd0:    ratio = RW'(10);
          3'd1:    ratio = RW'(2);
          3'd2:    ratio = RW'(8);
          3'd3:    ratio = RW'(4);
          3'd4:    ratio = RW'(5);
          3'd5:    ratio = RW'(7);
          3'd6:    ratio = RW'(9);
          default: ratio = RW'(6);
        endcase
      end
    end else begin : g_tab_b
      // R2 mapping
      always_comb begin
        case (sel)
          3'd0:    ratio = RW'(6);
          3'd1:    ratio = RW'(2);
          3'd2:    ratio = RW'(8);
          3'd3:    ratio = RW'(4);
          3'd4:    ratio = RW'(5);
          3'd5:    ratio = RW'(7);
          3'd6:    ratio = RW'(1);
          default: ratio = RW'(3);
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/postdiv_count.sv
`timescale 1ns/1ps
// Rising-edge period counter. Loads a new ratio only at a period boundary
// (R7) and restarts at a high phase after power-down (R6).
module postdiv_count #(
  parameter int RW = postdiv_pkg::RATIO_W
) (
  input  logic          osc_clk,
  input  logic          rst_n,
  input  logic          pwr_n,
  input  logic [RW-1:0] ratio_in,
  output logic [RW-1:0] ratio_q,
  output logic [RW-1:0] cnt,
  output logic          pos_q,
  output logic          odd_q,
  output logic          byp_q,
  output logic          run_q
);
  logic          last;
  logic [RW-1:0] ratio_nx;
  logic [RW-1:0] cnt_nx;
  logic [RW:0]   half_sum;
  logic [RW-1:0] half;
  logic          pos_nx;

  always_comb begin
    last     = !run_q || (cnt == ratio_q - 1'b1);
    ratio_nx = last ? ratio_in : ratio_q;
    cnt_nx   = last ? '0 : cnt + 1'b1;
    half_sum = {1'b0, ratio_nx} + 1'b1;
    half     = half_sum[RW:1];
    pos_nx   = (ratio_nx != RW'(1)) && (cnt_nx < half);
  end

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      cnt     <= '0;
      ratio_q <= RW'(1);
      pos_q   <= 1'b0;
      odd_q   <= 1'b0;
      byp_q   <= 1'b0;
    end else if (!pwr_n) begin
      run_q   <= 1'b0;
      cnt     <= '0;
      ratio_q <= ratio_in;
      pos_q   <= 1'b0;
      odd_q   <= 1'b0;
      byp_q   <= 1'b0;
    end else begin
      run_q   <= 1'b1;
      cnt     <= cnt_nx;
      ratio_q <= ratio_nx;
      pos_q   <= pos_nx;
      odd_q   <= ratio_nx[0] && (ratio_nx != RW'(1));
      byp_q   <= (ratio_nx == RW'(1));
    end
  end
endmodule

// File: rtl/postdiv_merge.sv
`timescale 1ns/1ps
// Falling-edge stage: trims odd high phases by half a period (R3) and
// gates the bypass path while the input clock is low (R4).
module postdiv_merge (
  input  logic osc_clk,
  input  logic rst_n,
  input  logic run_q,
  input  logic pos_q,
  input  logic odd_q,
  input  logic byp_q,
  output logic clk_out
);
  logic neg_q;
  logic bypn_q;

  always_ff @(negedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      neg_q  <= 1'b0;
      bypn_q <= 1'b0;
    end else begin
      neg_q  <= pos_q;
      bypn_q <= byp_q && run_q;
    end
  end

  assign clk_out = (osc_clk && bypn_q) || (pos_q && (odd_q ? neg_q : 1'b1));
endmodule

// File: rtl/postdiv_top.sv
`timescale 1ns/1ps
module postdiv_top #(
  parameter int TABLE = 0,
  parameter int SW    = postdiv_pkg::SEL_W,
  parameter int RW    = postdiv_pkg::RATIO_W
) (
  input  logic          osc_clk,
  input  logic          rst_n,
  input  logic          pwr_n,
  input  logic [SW-1:0] sel,
  output logic          clk_out,
  output logic          ref_out
);
  logic [RW-1:0] ratio_in;
  logic [RW-1:0] ratio_q;
  logic [RW-1:0] cnt;
  logic          pos_q;
  logic          odd_q;
  logic          byp_q;
  logic          run_q;

  postdiv_selmap #(.TABLE(TABLE), .SW(SW), .RW(RW)) u_map (
    .sel   (sel),
    .ratio (ratio_in)
  );

  postdiv_count #(.RW(RW)) u_cnt (
    .osc_clk  (osc_clk),
    .rst_n    (rst_n),
    .pwr_n    (pwr_n),
    .ratio_in (ratio_in),
    .ratio_q  (ratio_q),
    .cnt      (cnt),
    .pos_q    (pos_q),
    .odd_q    (odd_q),
    .byp_q    (byp_q),
    .run_q    (run_q)
  );

  postdiv_merge u_mrg (
    .osc_clk (osc_clk),
    .rst_n   (rst_n),
    .run_q   (run_q),
    .pos_q   (pos_q),
    .odd_q   (odd_q),
    .byp_q   (byp_q),
    .clk_out (clk_out)
  );

  // R8
  assign ref_out = osc_clk;
endmodule

// File: rtl/postdiv_chk.sv
`timescale 1ns/1ps
module postdiv_chk #(
  parameter int RW = postdiv_pkg::RATIO_W
) (
  input logic          osc_clk,
  input logic          rst_n,
  input logic          pwr_n,
  input logic          clk_out,
  input logic [RW-1:0] cnt,
  input logic [RW-1:0] ratio_q,
  input logic          pos_q
);
  logic warm;
  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) warm <= 1'b0;
    else        warm <= 1'b1;
  end

  AST_PD_LOW: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (warm && !pwr_n && $past(!pwr_n)) |-> !clk_out); // R5

  AST_CNT_RANGE: assert property (@(posedge osc_clk) disable iff (!rst_n)
    cnt < ratio_q); // R3

  AST_RATIO_AT_BOUNDARY: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (warm && ratio_q != $past(ratio_q)) |-> cnt == '0); // R7

  AST_HIGH_STARTS_PERIOD: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (warm && $rose(pos_q)) |-> cnt == '0); // R6

  AST_RATIO_LEGAL: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (ratio_q != '0) && (ratio_q <= RW'(10))); // R1
endmodule

bind postdiv_top postdiv_chk #(.RW(RW)) u_chk (
  .osc_clk (osc_clk),
  .rst_n   (rst_n),
  .pwr_n   (pwr_n),
  .clk_out (clk_out),
  .cnt     (cnt),
  .ratio_q (ratio_q),
  .pos_q   (pos_q)
);

// File: tb/postdiv_top_test.sv
`timescale 1ns/1ps
module postdiv_top_test;
  logic       osc_clk = 1'b0;
  logic       rst_n   = 1'b0;
  logic       pwr_n   = 1'b1;
  logic [2:0] sel     = 3'd7;
  logic       out_a, out_b, ref_a, ref_b;
  int         n_chk = 0;
  int         n_bad = 0;
  logic       s_a, s_b, s_clk, s_ref;

  always #2.5 osc_clk = ~osc_clk;

  postdiv_top #(.TABLE(0)) uut (
    .osc_clk(osc_clk), .rst_n(rst_n), .pwr_n(pwr_n), .sel(sel),
    .clk_out(out_a), .ref_out(ref_a));
  postdiv_top #(.TABLE(1)) uut_b (
    .osc_clk(osc_clk), .rst_n(rst_n), .pwr_n(pwr_n), .sel(sel),
    .clk_out(out_b), .ref_out(ref_b));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one sample per input half-period, 1.25 ns after each edge
  task automatic next_half();
    @(posedge osc_clk or negedge osc_clk);
    #1.25;
    s_a = out_a; s_b = out_b; s_clk = osc_clk; s_ref = ref_a;
  endtask

  function automatic logic pick(input bit b);
    return b ? s_b : s_a;
  endfunction

  // waits for a rising output, then counts the high and low run lengths
  task automatic get_runs(input bit b, output int h, output int l);
    int g = 0;
    h = 0; l = 0;
    next_half();
    while (pick(b) !== 1'b0 && g < 200) begin next_half(); g++; end
    while (pick(b) !== 1'b1 && g < 200) begin next_half(); g++; end
    while (pick(b) === 1'b1 && g < 200) begin h++; next_half(); g++; end
    while (pick(b) === 1'b0 && g < 200) begin l++; next_half(); g++; end
  endtask

  task automatic t_ratio(input bit b, input int code, input int n, input string req);
    int h, l;
    sel = 3'(code);
    repeat (50) next_half();
    get_runs(b, h, l);
    check($sformatf("%s code%0d high", req, code), h, n);
    check($sformatf("%s code%0d low", req, code), l, n);
  endtask

  task automatic t_reset();
    // R9
    repeat (4) next_half();
    check("R9 out low in reset", int'(s_a), 0);
    check("R9 out_b low in reset", int'(s_b), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_ref();
    int bad = 0;
    for (int i = 0; i < 20; i++) begin
      next_half();
      if (s_ref !== s_clk) bad++;
    end
    check("R8 ref follows input", bad, 0);
  endtask

  task automatic t_pd();
    int hi = 0;
    sel = 3'd1;
    repeat (20) next_half();
    pwr_n = 1'b0;
    repeat (4) next_half();
    for (int i = 0; i < 30; i++) begin
      next_half();
      if (s_a !== 1'b0 || s_b !== 1'b0) hi++;
    end
    check("R5 output held low in power-down", hi, 0);
  endtask

  // R6: release just after a rising-edge sample; ratio 2 rises at next edge
  task automatic t_resume_even();
    logic [3:0] seq;
    sel = 3'd1;
    pwr_n = 1'b0;
    repeat (6) next_half();
    do next_half(); while (s_clk !== 1'b1);
    pwr_n = 1'b1;
    for (int i = 0; i < 4; i++) begin next_half(); seq[i] = s_a; end
    check("R6 even resume sequence", int'(seq), int'(4'b0110));
  endtask

  // R6: ratio 5 rises half a period after the first edge, high 5 halves
  task automatic t_resume_odd();
    logic [8:0] seq;
    sel = 3'd4;
    pwr_n = 1'b0;
    repeat (6) next_half();
    do next_half(); while (s_clk !== 1'b1);
    pwr_n = 1'b1;
    for (int i = 0; i < 9; i++) begin next_half(); seq[i] = s_a; end
    check("R6 odd resume sequence", int'(seq), int'(9'b001111100));
  endtask

  // R7: change 10 -> 4 in mid high phase
  task automatic t_switch();
    int h = 0, l = 0, h2, l2;
    sel = 3'd0;
    repeat (50) next_half();
    next_half();
    while (s_a !== 1'b0) next_half();
    while (s_a !== 1'b1) next_half();
    h = 1;
    for (int i = 0; i < 2; i++) begin next_half(); h++; end
    sel = 3'd3;
    next_half();
    while (s_a === 1'b1) begin h++; next_half(); end
    while (s_a === 1'b0) begin l++; next_half(); end
    check("R7 old high phase kept", h, 10);
    check("R7 old low phase kept", l, 10);
    h2 = 0; l2 = 0;
    while (s_a === 1'b1) begin h2++; next_half(); end
    while (s_a === 1'b0) begin l2++; next_half(); end
    check("R7 new high phase", h2, 4);
    check("R7 new low phase", l2, 4);
  endtask

  initial begin
    #250000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_ref();
    // R1 / R3 table A, all codes
    t_ratio(0, 0, 10, "R1");
    t_ratio(0, 1, 2,  "R1");
    t_ratio(0, 2, 8,  "R1");
    t_ratio(0, 3, 4,  "R1");
    t_ratio(0, 4, 5,  "R3");
    t_ratio(0, 5, 7,  "R3");
    t_ratio(0, 6, 9,  "R3");
    t_ratio(0, 7, 6,  "R1");
    // R2 / R4 table B
    t_ratio(1, 0, 6, "R2");
    t_ratio(1, 6, 1, "R4");
    t_ratio(1, 7, 3, "R2");
    t_pd();
    t_resume_even();
    t_resume_odd();
    t_switch();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule